// File: doc/BRIEF.md
# Acquisition record end controller

This block closes one acquisition record in a digitizer, and it runs entirely on the conversion clock. Software first loads a post-record start count, then sets the enable bit in the mode register. The block then accepts converted sample words over a valid/ready stream. For each accepted word it emits one memory write strobe with a 12-bit write address, and the address then steps by one and wraps at full range.

When the address counter wraps, a sticky pre-full flag rises. In calibration mode this flag serves as the trigger; otherwise an external trigger input does. The trigger is registered into a triggered flag. From then on the post-record counter advances once per clock until it reaches the terminal value 0xFF0. One clock later the active-low end-of-record output falls. The stream then stops accepting words, and both counters freeze. They stay readable until software clears the enable bit.

Stream rules: a word transfers on a rising clock edge where `smp_valid` and `smp_ready` are both high. `smp_ready` depends only on internal state and never on `smp_valid`. The source may hold or drop `smp_valid` at any time. Memory is written in the same cycle as the transfer, with no stall path.

Top module: `acq_record_ctrl`

## Requirements
- R1: After asynchronous reset (`rst_n` low): `end_rec_n`=1, `smp_ready`=0, `mem_we`=0, `trig_flag`=0, `pre_full`=0, and both counter readbacks are 0.
- R2: A write with `cfg_sel`=0 is a mode write. In a mode write, bit 4 of `cfg_wdata` is the enable bit and bit 1 is the calibration-trigger select. A mode write that sets the enable bit while the block is disabled is a start. On that same edge, a start clears the address counter, `pre_full`, `trig_flag` and the end flag, and `smp_ready` is high in the following cycle.
- R3: In a cycle where `smp_valid` and `smp_ready` are both high, `mem_we`=1, `mem_addr` equals the address counter, and `mem_wdata` equals `smp_data`; the counter then advances by one. No write occurs in any other cycle.
- R4: The address counter wraps from 0xFFF to 0x000. The accepted word at 0xFFF sets `pre_full`, which stays high until the next start.
- R5: While enabled and not ended, the trigger source is `pre_full` when the calibration bit is 1, and `ext_trig` when it is 0. A high trigger source sets `trig_flag` at the next edge, and `trig_flag` is sticky.
- R6: A write with `cfg_sel`=1 loads `cfg_wdata` into the post-record counter. While `trig_flag` is high and the record has not ended, the counter advances by one every clock, whether or not a word is transferred.
- R7: The post-record counter stops at 0xFF0. One clock after it reaches that value, `end_rec_n` goes low.
- R8: While `end_rec_n` is low, `smp_ready` is 0, no memory write occurs, and both counters hold their values.
- R9: A mode write that clears the enable bit raises `end_rec_n` and clears `trig_flag` at that edge. Both counters keep their values. While disabled, `ext_trig` and `smp_valid` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = mode register, 1 = post-record preload |
| cfg_wdata | input | 12 | Register write data |
| ext_trig | input | 1 | External trigger condition |
| smp_valid | input | 1 | Sample word valid |
| smp_ready | output | 1 | Block accepts a sample word |
| smp_data | input | 16 | Sample word |
| mem_we | output | 1 | Acquisition memory write strobe |
| mem_addr | output | 12 | Acquisition memory write address |
| mem_wdata | output | 16 | Acquisition memory write data |
| end_rec_n | output | 1 | End of record, active low |
| pre_full | output | 1 | Sticky address-wrap flag |
| trig_flag | output | 1 | Triggered flag |
| addr_cnt_rd | output | 12 | Address counter readback |
| post_cnt_rd | output | 12 | Post-record counter readback |

## Verification
The calibration trigger is the hardest condition to reach, because it needs a full 4096 accepted words before the address wraps. The bench streams an unbroken run of valid words from start, with a preload of 0xF9F. It then checks the exact cycle where `pre_full`, `trig_flag` and `end_rec_n` change, and the final address of 0x053. A second record uses the external trigger and drops `smp_valid` during the post count. This shows that the post count ticks on clocks, not on words, and that the end of record cuts off a source that is still offering data.

// File: rtl/acq_rec_pkg.sv
package acq_rec_pkg;
  // Mode register bit positions decoded by the controller
  localparam int MODE_EN_BIT  = 4;
  localparam int MODE_CAL_BIT = 1;

  typedef struct packed {
    logic en;
    logic cal;
  } mode_t;
endpackage

// File: rtl/acq_mode_reg.sv
module acq_mode_reg
  import acq_rec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_we,
  input  logic  cfg_sel,
  input  logic  en_bit,
  input  logic  cal_bit,
  output mode_t mode_o,
  output logic  start_o,
  output logic  clr_o
);
  mode_t mode_q;
  logic  mode_we;

  assign mode_we = cfg_we && !cfg_sel;
  assign start_o = mode_we && en_bit && !mode_q.en;
  assign clr_o   = mode_we && !en_bit && mode_q.en;
  assign mode_o  = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q.en  <= en_bit;
      mode_q.cal <= cal_bit;
    end
  end

  assert_start_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> mode_q.en);
endmodule

// File: rtl/acq_wr_addr.sv
module acq_wr_addr #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              smp_ready,
  output logic              mem_we,
  output logic [CNT_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [CNT_W-1:0]  addr_q,
  output logic              pre_full
);
  localparam logic [CNT_W-1:0] ADDR_MAX = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic fire;

  assign smp_ready = active;
  assign fire      = smp_valid && active;
  assign mem_we    = fire;
  assign mem_addr  = addr_q;
  assign mem_wdata = smp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      pre_full <= 1'b0;
    end else if (start) begin
      addr_q   <= '0;
      pre_full <= 1'b0;
    end else if (fire) begin
      addr_q <= addr_q + ONE;
      if (addr_q == ADDR_MAX) pre_full <= 1'b1;
    end
  end

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !start) |=> (addr_q == $past(addr_q) + ONE));
  assert_wrap_sets_prefull_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !start && addr_q == ADDR_MAX) |=> (pre_full && addr_q == '0));
  assert_prefull_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_full && !start) |=> pre_full);
endmodule

// File: rtl/acq_post_ctr.sv
module acq_post_ctr #(
  parameter int              CNT_W   = 12,
  parameter logic [CNT_W-1:0] END_VAL = 12'hFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clr,
  input  logic             active,
  input  logic             cal,
  input  logic             pre_full,
  input  logic             ext_trig,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             trig_q,
  output logic             ended_q,
  output logic [CNT_W-1:0] post_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic trig_src;
  logic at_end;
  logic counting;

  assign trig_src = cal ? pre_full : ext_trig;
  assign at_end   = (post_q == END_VAL);
  assign counting = trig_q && !ended_q && !at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      ended_q <= 1'b0;
    end else if (start || clr) begin
      trig_q  <= 1'b0;
      ended_q <= 1'b0;
    end else begin
      if (active && trig_src) trig_q <= 1'b1;
      if (trig_q && !ended_q && at_end) ended_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        post_q <= '0;
    else if (load)     post_q <= load_val;
    else if (counting) post_q <= post_q + ONE;
  end

  assert_post_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !load) |=> (post_q == $past(post_q) + ONE));
  assert_end_after_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && !ended_q && at_end && !start && !clr) |=> ended_q);
  assert_post_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ended_q && !load) |=> $stable(post_q));
  assert_clear_drops_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!trig_q && !ended_q));
endmodule

// File: rtl/acq_record_ctrl.sv
module acq_record_ctrl
  import acq_rec_pkg::*;
#(
  parameter int              CNT_W    = 12,
  parameter int              DATA_W   = 16,
  parameter logic [CNT_W-1:0] POST_END = 12'hFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic              ext_trig,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic              mem_we,
  output logic [CNT_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              end_rec_n,
  output logic              pre_full,
  output logic              trig_flag,
  output logic [CNT_W-1:0]  addr_cnt_rd,
  output logic [CNT_W-1:0]  post_cnt_rd
);
  mode_t mode;
  logic  start, clr, active, ended;

  acq_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_sel),
    .en_bit  (cfg_wdata[MODE_EN_BIT]),
    .cal_bit (cfg_wdata[MODE_CAL_BIT]),
    .mode_o  (mode),
    .start_o (start),
    .clr_o   (clr)
  );

  assign active = mode.en && !ended;

  acq_wr_addr #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .active    (active),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_ready (smp_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .addr_q    (addr_cnt_rd),
    .pre_full  (pre_full)
  );

  acq_post_ctr #(.CNT_W(CNT_W), .END_VAL(POST_END)) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .clr      (clr),
    .active   (active),
    .cal      (mode.cal),
    .pre_full (pre_full),
    .ext_trig (ext_trig),
    .load     (cfg_we && cfg_sel),
    .load_val (cfg_wdata),
    .trig_q   (trig_flag),
    .ended_q  (ended),
    .post_q   (post_cnt_rd)
  );

  assign end_rec_n = !ended;

  assert_no_write_when_ended_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !end_rec_n |-> !mem_we);
  assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_rec_n && !start) |=> $stable(addr_cnt_rd));
endmodule

// File: tb/acq_record_ctrl_tb.sv
module acq_record_ctrl_tb_top;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [11:0] cfg_wdata;
  logic        ext_trig, smp_valid, smp_ready;
  logic [15:0] smp_data;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        end_rec_n, pre_full, trig_flag;
  logic [11:0] addr_cnt_rd, post_cnt_rd;

  int vectors = 0;
  int fails   = 0;
  logic [27:0] exp_q[$];
  logic [11:0] exp_addr;

  always #(CLK_PER/2) clk = ~clk;

  acq_record_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_trig(ext_trig), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .end_rec_n(end_rec_n),
    .pre_full(pre_full), .trig_flag(trig_flag), .addr_cnt_rd(addr_cnt_rd),
    .post_cnt_rd(post_cnt_rd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // Drive one cycle shortly after the rising edge, return at the falling edge.
  task automatic cyc(input logic v, input logic [15:0] d, input logic t,
                     input logic we, input logic sel, input logic [11:0] wd,
                     input logic accept);
    @(posedge clk);
    #1;
    smp_valid = v; smp_data = d; ext_trig = t;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    if (accept) begin
      exp_q.push_back({exp_addr, d});
      exp_addr = exp_addr + 12'd1;
    end
    @(negedge clk);
  endtask

  // Scoreboard monitor: every memory write must match the next expected item (R3)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_we === 1'b1) begin
      if (exp_q.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R3 unexpected write actual=%0h/%0h expected=none", mem_addr, mem_wdata);
      end else begin
        logic [27:0] e;
        e = exp_q.pop_front();
        chk("R3 write addr/data", {4'h0, mem_addr, mem_wdata}, {4'h0, e});
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
    ext_trig = 0; smp_valid = 0; smp_data = '0; exp_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 end_rec_n", end_rec_n, 1);
    chk("R1 smp_ready", smp_ready, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 trig_flag", trig_flag, 0);
    chk("R1 pre_full", pre_full, 0);
    chk("R1 addr", addr_cnt_rd, 0);
    chk("R1 post", post_cnt_rd, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // Record A: calibration trigger from address wrap, preload 0xF9F
    cyc(0, 0, 0, 1, 1, 12'hF9F, 0);
    cyc(0, 0, 0, 1, 0, 12'h012, 0);
    chk("R2 ready before start edge", smp_ready, 0);
    exp_addr = '0;
    for (int j = 1; j <= 4185; j++) begin
      cyc(1, 16'(j) ^ 16'hA5A5, 0, 0, 0, 0, j <= 4179);
      chk("R7 end_rec_n timing", end_rec_n, (j >= 4180) ? 0 : 1);
      chk("R8 ready", smp_ready, (j <= 4179) ? 1 : 0);
      if (j == 1)    chk("R2 ready after start", smp_ready, 1);
      if (j == 4096) chk("R4 pre_full before wrap", pre_full, 0);
      if (j == 4097) begin
        chk("R4 pre_full after wrap", pre_full, 1);
        chk("R4 address wrapped", addr_cnt_rd, 0);
        chk("R5 trig not yet", trig_flag, 0);
      end
      if (j == 4098) chk("R5 cal trigger registered", trig_flag, 1);
      if (j == 4100) chk("R6 post ticks", post_cnt_rd, 12'hFA1);
      if (j == 4150) chk("R4 pre_full sticky", pre_full, 1);
      if (j == 4180) chk("R7 post holds terminal", post_cnt_rd, 12'hFF0);
    end
    chk("R8 post frozen", post_cnt_rd, 12'hFF0);
    chk("R8 addr frozen", addr_cnt_rd, 12'h053);

    // Clear enable, then poke inputs while disabled
    cyc(0, 0, 0, 1, 0, 12'h000, 0);
    for (int k = 1; k <= 3; k++) begin
      cyc(1, 16'hDEAD, 1, 0, 0, 0, 0);
      chk("R9 end_rec_n released", end_rec_n, 1);
      chk("R9 trig cleared and ext_trig ignored", trig_flag, 0);
      chk("R9 ready low when disabled", smp_ready, 0);
      chk("R9 addr retained", addr_cnt_rd, 12'h053);
      chk("R9 post retained", post_cnt_rd, 12'hFF0);
    end

    // Record B: external trigger with gaps in the stream, preload 0xFEB
    cyc(0, 0, 0, 1, 1, 12'hFEB, 0);
    cyc(0, 0, 0, 1, 0, 12'h010, 0);
    chk("R6 preload visible", post_cnt_rd, 12'hFEB);
    chk("R9 ext_trig ignored while disabled", trig_flag, 0);
    exp_addr = '0;
    for (int j = 1; j <= 20; j++) begin
      logic v;
      v = (j <= 10) || (j >= 14);
      cyc(v, 16'(j) ^ 16'h3C3C, j == 10, 0, 0, 0, v && (j <= 16));
      chk("R7 end_rec_n timing B", end_rec_n, (j >= 17) ? 0 : 1);
      if (j == 1)  chk("R2 start cleared pre_full", pre_full, 0);
      if (j == 1)  chk("R2 start cleared addr", addr_cnt_rd, 0);
      if (j == 11) chk("R5 ext trigger registered", trig_flag, 1);
      if (j == 11) chk("R6 post before tick", post_cnt_rd, 12'hFEB);
      if (j == 13) chk("R6 post ticks without words", post_cnt_rd, 12'hFED);
      if (j == 16) chk("R7 terminal reached", post_cnt_rd, 12'hFF0);
    end
    chk("R3 addr after gaps", addr_cnt_rd, 12'h00D);
    chk("R4 no wrap in record B", pre_full, 0);
    chk("R8 post frozen B", post_cnt_rd, 12'hFF0);

    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R3 all expected writes seen", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule